// File: doc/BRIEF.md
# Multiplexed Parallel Register Bus Slave

This block is the device side of a narrow host bus in which address and data travel over the same 8-bit lanes. The host frames each transfer with an active-low chip select and one active-low strobe, either read or write. A phase line tells the slave what the byte on the lanes means. With the phase line high, a write loads a register index. With it low, read and write cycles reach the register that the held index selects. The index is not stepped forward after an access, so one index serves any number of data cycles.

The slave answers each strobe with an active-low ready. Ready goes low after a fixed number of internal cycles and stays low until the host lets go of the strobe. The slave holds a small register file for a dual common-interface controller. The file covers:

- an interrupt control register;
- two bus control registers;
- a card address pair and a card data byte;
- a PID table address pair and a PID table data byte;
- two stream clock dividers;
- a read-only revision byte.

All register contents and one-cycle write pulses are brought out to the internal logic. An internal event raises a pending interrupt. That interrupt drives an active-low interrupt pin while the interrupt control register enables it. A read of the interrupt control register acknowledges the interrupt. The read data path is modelled as a separate output with its own output-enable, in place of a bidirectional pin.

Top module: `muxbus_regslave`

## Requirements
- R1: After reset, ready and interrupt are high, the output-enable is low, every writable register and the latched index are 0x00, and both stream enables are 0.
- R2: With the bus inputs applied between clock edges, ready goes low exactly WAIT_CYC+2 rising edges after an accepted strobe is presented. It stays low while the strobe is held, and returns high 2 rising edges after the strobe is released.
- R3: A write with the phase line high loads the byte on the lanes as the register index. The index stays in force, unchanged, across any number of later data cycles.
- R4: A data-phase write to a writable index (0x00, 0x01, 0x04 to 0x0A, 0x0C, 0x0D) stores the byte in that register. The register is visible at byte position index of the register image output. Write pulse bit index is high for exactly one cycle, the first cycle in which ready is low.
- R5: A data-phase write to index 0x0F (revision), to an unused index (0x02, 0x03, 0x0B, 0x0E) or to any index of 0x10 or above changes no register and raises no write pulse.
- R6: A data-phase read returns the selected register on the read data output while ready is low. Index 0x0F returns the REVISION parameter. Unused indices and indices of 0x10 or above return 0x00.
- R7: The output-enable is high exactly while chip select and read are both low and the phase line is low.
- R8: The two stream enable outputs follow bits 5 and 4 of bus control 2 (index 0x01), bit 5 on output bit 1.
- R9: A one-cycle event input sets a pending interrupt flag. The interrupt output is low exactly while that flag is set and both bit 6 and bit 2 of the interrupt control register (index 0x00) are 1. Writing 0x44 sets both bits.
- R10: A data-phase read of index 0x00 returns the stored byte with bit 0 replaced by the pending flag, and clears the flag. An event in the same cycle as that read leaves the flag set.
- R11: With chip select high, or with both strobes low at once, no access takes place: ready stays high and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_sel_addr | input | 1 | Phase line: 1 = index phase, 0 = data phase |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_din | input | 8 | Byte driven by the host on the shared lanes |
| bus_dout | output | 8 | Read data the slave puts on the lanes |
| bus_doe | output | 1 | Output-enable for bus_dout onto the lanes |
| bus_rdy_n | output | 1 | Ready, active low |
| bus_irq_n | output | 1 | Interrupt, active low |
| irq_evt_i | input | 1 | Internal interrupt event, one-cycle pulse |
| reg_image_o | output | 128 | All 16 register bytes, index i at bits 8i+7:8i |
| wr_pulse_o | output | 16 | One-cycle write pulse per register index |
| ts_en_o | output | 2 | Stream output enables from bus control 2 |

## Verification
The hardest case to reach is an internal event that arrives on the very clock edge at which a read of the interrupt control register takes effect. The set must win over the acknowledge. Random traffic almost never lines these two up. A directed cycle therefore counts the clock edges after the strobe is presented and pulses the event on edge WAIT_CYC+2, the edge that commits the read. Random mixes of index writes (some outside the map), data writes, reads and events check a second point against a bench model: an index is reused and never stepped forward.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

  localparam int NREG = 16;

  localparam int IDX_INTCTL   = 0;
  localparam int IDX_BUSCTL2  = 1;
  localparam int IDX_CADDR_LO = 4;
  localparam int IDX_CADDR_HI = 5;
  localparam int IDX_CDATA    = 6;
  localparam int IDX_BUSCTL   = 7;
  localparam int IDX_PADDR_LO = 8;
  localparam int IDX_PADDR_HI = 9;
  localparam int IDX_PDATA    = 10;
  localparam int IDX_DIV_A    = 12;
  localparam int IDX_DIV_B    = 13;
  localparam int IDX_REV      = 15;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_BUSY = 2'd1,
    HS_ACK  = 2'd2
  } hs_state_e;

  // 1 when a register exists at index and the host may write it
  function automatic bit reg_is_writable(input int idx);
    return (idx == IDX_INTCTL) || (idx == IDX_BUSCTL2) ||
           (idx >= IDX_CADDR_LO && idx <= IDX_PDATA) ||
           (idx == IDX_DIV_A) || (idx == IDX_DIV_B);
  endfunction

  // interrupt output is allowed when both enable bits are set
  function automatic logic irq_allowed(input logic [7:0] ctl);
    return ctl[6] & ctl[2];
  endfunction

  // an accepted strobe: exactly one of read/write active under select
  function automatic logic strobe_ok(input logic cs_n, input logic rd_n,
                                     input logic wr_n);
    return !cs_n && (rd_n != wr_n);
  endfunction

endpackage

// File: rtl/muxbus_sync.sv
module muxbus_sync #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sel_addr,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic [DW-1:0] din,
  output logic          cs_n_q,
  output logic          sel_addr_q,
  output logic          wr_n_q,
  output logic          rd_n_q,
  output logic [DW-1:0] din_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q     <= 1'b1;
      sel_addr_q <= 1'b0;
      wr_n_q     <= 1'b1;
      rd_n_q     <= 1'b1;
      din_q      <= '0;
    end else begin
      cs_n_q     <= cs_n;
      sel_addr_q <= sel_addr;
      wr_n_q     <= wr_n;
      rd_n_q     <= rd_n;
      din_q      <= din;
    end
  end

endmodule

// File: rtl/muxbus_handshake.sv
module muxbus_handshake #(
  parameter int WAIT_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_q,
  input  logic wr_n_q,
  input  logic rd_n_q,
  output logic commit,
  output logic op_rd,
  output logic rdy_n
);
  import muxbus_pkg::*;

  localparam int CW = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC + 1);

  hs_state_e       state;
  logic [CW-1:0]   cnt;
  logic            strobe;

  assign strobe = strobe_ok(cs_n_q, rd_n_q, wr_n_q);
  assign op_rd  = !rd_n_q;
  assign commit = (state == HS_BUSY) && strobe && (cnt == '0);
  assign rdy_n  = (state != HS_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= HS_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        HS_IDLE: if (strobe) begin
          state <= HS_BUSY;
          cnt   <= CW'(WAIT_CYC - 1);
        end
        HS_BUSY: begin
          if (!strobe)          state <= HS_IDLE;
          else if (cnt == '0)   state <= HS_ACK;
          else                  cnt   <= cnt - 1'b1;
        end
        HS_ACK: if (!strobe) state <= HS_IDLE;
        default: state <= HS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/muxbus_regfile.sv
module muxbus_regfile #(
  parameter int          NREG     = 16,
  parameter logic [7:0]  REVISION = 8'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              op_addr,
  input  logic              op_rd,
  input  logic [7:0]        din,
  input  logic              irq_evt,
  output logic [7:0]        rdata,
  output logic [NREG*8-1:0] image,
  output logic [NREG-1:0]   wr_pulse,
  output logic              irq_n
);
  import muxbus_pkg::*;

  logic [7:0] idx_q;
  logic       pend_q;
  logic       data_wr, data_rd, addr_wr, hit_ctl;
  logic [7:0] rd_val;

  assign data_wr = commit && !op_addr && !op_rd;
  assign data_rd = commit && !op_addr &&  op_rd;
  assign addr_wr = commit &&  op_addr && !op_rd;
  assign hit_ctl = (idx_q == 8'(IDX_INTCTL));

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (reg_is_writable(i)) begin : g_rw
      logic [7:0] q;
      logic       p;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
          p <= 1'b0;
        end else begin
          p <= data_wr && (idx_q == 8'(i));
          if (data_wr && (idx_q == 8'(i))) q <= din;
        end
      end
      assign image[i*8 +: 8] = q;
      assign wr_pulse[i]     = p;
    end else if (i == IDX_REV) begin : g_ro
      assign image[i*8 +: 8] = REVISION;
      assign wr_pulse[i]     = 1'b0;
    end else begin : g_none
      assign image[i*8 +: 8] = 8'h00;
      assign wr_pulse[i]     = 1'b0;
    end
  end

  always_comb begin
    rd_val = 8'h00;
    if (int'(idx_q) < NREG) rd_val = image[int'(idx_q)*8 +: 8];
    if (hit_ctl) rd_val[0] = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      rdata  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (addr_wr) idx_q <= din;
      if (data_rd) rdata <= rd_val;
      if (irq_evt)                 pend_q <= 1'b1;
      else if (data_rd && hit_ctl) pend_q <= 1'b0;
    end
  end

  assign irq_n = !(pend_q && irq_allowed(image[IDX_INTCTL*8 +: 8]));

endmodule

// File: rtl/muxbus_regslave.sv
module muxbus_regslave #(
  parameter int         WAIT_CYC = 2,
  parameter logic [7:0] REVISION = 8'h11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_cs_n,
  input  logic         bus_sel_addr,
  input  logic         bus_wr_n,
  input  logic         bus_rd_n,
  input  logic [7:0]   bus_din,
  output logic [7:0]   bus_dout,
  output logic         bus_doe,
  output logic         bus_rdy_n,
  output logic         bus_irq_n,
  input  logic         irq_evt_i,
  output logic [127:0] reg_image_o,
  output logic [15:0]  wr_pulse_o,
  output logic [1:0]   ts_en_o
);
  import muxbus_pkg::*;

  logic       cs_n_q, sel_q, wr_n_q, rd_n_q;
  logic [7:0] din_q;
  logic       commit_w, op_rd_w;

  muxbus_sync #(.DW(8)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .cs_n(bus_cs_n), .sel_addr(bus_sel_addr), .wr_n(bus_wr_n),
    .rd_n(bus_rd_n), .din(bus_din),
    .cs_n_q(cs_n_q), .sel_addr_q(sel_q), .wr_n_q(wr_n_q),
    .rd_n_q(rd_n_q), .din_q(din_q)
  );

  muxbus_handshake #(.WAIT_CYC(WAIT_CYC)) u_hs (
    .clk(clk), .rst_n(rst_n),
    .cs_n_q(cs_n_q), .wr_n_q(wr_n_q), .rd_n_q(rd_n_q),
    .commit(commit_w), .op_rd(op_rd_w), .rdy_n(bus_rdy_n)
  );

  muxbus_regfile #(.NREG(NREG), .REVISION(REVISION)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .commit(commit_w), .op_addr(sel_q), .op_rd(op_rd_w), .din(din_q),
    .irq_evt(irq_evt_i),
    .rdata(bus_dout), .image(reg_image_o), .wr_pulse(wr_pulse_o),
    .irq_n(bus_irq_n)
  );

  assign bus_doe = !bus_cs_n && !bus_rd_n && !bus_sel_addr;
  assign ts_en_o = reg_image_o[IDX_BUSCTL2*8+5 -: 2];

endmodule

// File: rtl/muxbus_checker.sv
module muxbus_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_cs_n,
  input logic        bus_rd_n,
  input logic        bus_sel_addr,
  input logic        bus_doe,
  input logic        bus_rdy_n,
  input logic        bus_irq_n,
  input logic        commit_w,
  input logic [1:0]  irq_cfg,
  input logic [15:0] wr_pulse_o
);

  // indices 2, 3, 11, 14 and 15 never produce a write pulse
  localparam logic [15:0] NO_PULSE_MASK = 16'hC80C;

  assert_doe_needs_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> (!bus_cs_n && !bus_rd_n && !bus_sel_addr));

  assert_pulse_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_pulse_o));

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_pulse_o) |=> !(|wr_pulse_o));

  assert_no_ro_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse_o & NO_PULSE_MASK) == 16'h0000);

  assert_ready_after_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_w |=> !bus_rdy_n);

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_irq_n |-> (irq_cfg == 2'b11));

endmodule

bind muxbus_regslave muxbus_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_sel_addr(bus_sel_addr),
  .bus_doe(bus_doe), .bus_rdy_n(bus_rdy_n), .bus_irq_n(bus_irq_n),
  .commit_w(commit_w),
  .irq_cfg({reg_image_o[6], reg_image_o[2]}),
  .wr_pulse_o(wr_pulse_o)
);

// File: tb/muxbus_regslave_bench.sv
module muxbus_regslave_bench;
  localparam int         WAIT_CYC = 2;
  localparam logic [7:0] REV      = 8'h11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_cs_n = 1'b1, bus_sel_addr = 1'b0, bus_wr_n = 1'b1, bus_rd_n = 1'b1;
  logic [7:0] bus_din = 8'h00;
  logic [7:0] bus_dout;
  logic bus_doe, bus_rdy_n, bus_irq_n;
  logic irq_evt = 1'b0;
  logic [127:0] reg_image_o;
  logic [15:0] wr_pulse_o;
  logic [1:0] ts_en_o;

  always #4 clk = ~clk;

  muxbus_regslave #(.WAIT_CYC(WAIT_CYC), .REVISION(REV)) u_muxbus_regslave (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_sel_addr(bus_sel_addr),
    .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_rdy_n(bus_rdy_n),
    .bus_irq_n(bus_irq_n), .irq_evt_i(irq_evt), .reg_image_o(reg_image_o),
    .wr_pulse_o(wr_pulse_o), .ts_en_o(ts_en_o)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  logic [7:0] m_reg [16];
  logic [7:0] m_idx;
  bit         m_pend;

  function automatic bit b_writable(input int i);
    return i == 0 || i == 1 || (i >= 4 && i <= 10) || i == 12 || i == 13;
  endfunction

  function automatic logic [7:0] b_read(input logic [7:0] idx);
    logic [7:0] v;
    if (idx == 8'h0F)                     v = REV;
    else if (idx < 8'd16 && b_writable(int'(idx))) v = m_reg[idx[3:0]];
    else                                  v = 8'h00;
    if (idx == 8'h00) v = {m_reg[0][7:1], m_pend};
    return v;
  endfunction

  function automatic logic [127:0] b_image();
    logic [127:0] e;
    for (int i = 0; i < 16; i++)
      e[i*8 +: 8] = b_writable(i) ? m_reg[i] : (i == 15 ? REV : 8'h00);
    return e;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_state();
    chk("R9", "irq_n", {127'd0, bus_irq_n},
        {127'd0, !(m_pend && m_reg[0][6] && m_reg[0][2])});
    chk("R8", "ts_en", {126'd0, ts_en_o}, {126'd0, m_reg[1][5:4]});
    chk("R4", "image", reg_image_o, b_image());
  endtask

  // one host transfer; evt_commit pulses the event on the committing edge
  task automatic bus_op(input bit addr_ph, input bit rd, input logic [7:0] d,
                        input bit evt_commit, output logic [7:0] rdata,
                        output bit doe, output logic [15:0] pulse);
    int lat = 0;
    bus_cs_n = 1'b0; bus_sel_addr = addr_ph; bus_rd_n = !rd; bus_wr_n = rd;
    bus_din = d;
    forever begin
      @(negedge clk);
      lat++;
      if (!bus_rdy_n || lat > 64) break;
      irq_evt = evt_commit && (lat == WAIT_CYC + 1);
    end
    irq_evt = 1'b0;
    chk("R2", "ready latency", 128'(lat), 128'(WAIT_CYC + 2));
    rdata = bus_dout; doe = bus_doe; pulse = wr_pulse_o;
    chk("R7", "doe during cycle", {127'd0, doe}, {127'd0, rd && !addr_ph});
    bus_cs_n = 1'b1; bus_rd_n = 1'b1; bus_wr_n = 1'b1; bus_sel_addr = 1'b0;
    #1;
    chk("R7", "doe after release", {127'd0, bus_doe}, 128'd0);
    lat = 0;
    forever begin
      @(negedge clk);
      lat++;
      if (bus_rdy_n || lat > 64) break;
    end
    chk("R2", "release latency", 128'(lat), 128'd2);
  endtask

  task automatic do_addr(input logic [7:0] idx);
    logic [7:0] r; bit o; logic [15:0] p;
    bus_op(1'b1, 1'b0, idx, 1'b0, r, o, p);
    m_idx = idx;
    chk("R3", "no pulse on index write", 128'(p), 128'd0);
  endtask

  task automatic do_write(input logic [7:0] d);
    logic [7:0] r; bit o; logic [15:0] p; logic [15:0] ep;
    bus_op(1'b0, 1'b0, d, 1'b0, r, o, p);
    ep = 16'd0;
    if (m_idx < 8'd16 && b_writable(int'(m_idx))) begin
      m_reg[m_idx[3:0]] = d;
      ep[m_idx[3:0]] = 1'b1;
      chk("R4", "write pulse", 128'(p), 128'(ep));
    end else begin
      chk("R5", "no pulse on ignored write", 128'(p), 128'd0);
    end
    chk_state();
  endtask

  task automatic do_read(input bit evt_commit, input string req);
    logic [7:0] r; bit o; logic [15:0] p; logic [7:0] e;
    e = b_read(m_idx);
    bus_op(1'b0, 1'b1, 8'h00, evt_commit, r, o, p);
    chk(req, "read data", 128'(r), 128'(e));
    if (m_idx == 8'h00) m_pend = evt_commit;
    if (evt_commit) m_pend = 1'b1;
    chk_state();
  endtask

  task automatic do_event();
    irq_evt = 1'b1;
    @(negedge clk);
    irq_evt = 1'b0;
    m_pend = 1'b1;
    chk_state();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = int'($urandom(32'h5EED_0042));
    for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
    m_idx = 8'h00; m_pend = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "rdy_n", {127'd0, bus_rdy_n}, 128'd1);
    chk("R1", "irq_n", {127'd0, bus_irq_n}, 128'd1);
    chk("R1", "doe", {127'd0, bus_doe}, 128'd0);
    chk("R1", "image", reg_image_o, b_image());
    chk("R1", "ts_en", 128'(ts_en_o), 128'd0);
    do_read(1'b0, "R1");

    // R3 index is reused, not stepped
    do_addr(8'h05);
    do_write(8'hA1);
    do_write(8'hB2);
    do_read(1'b0, "R3");
    do_read(1'b0, "R3");
    do_addr(8'h04);
    do_read(1'b0, "R3");

    // R5 ignored writes, R6 read-only and unused reads
    do_addr(8'h0F); do_write(8'h5A); do_read(1'b0, "R6");
    do_addr(8'h0B); do_write(8'hFF); do_read(1'b0, "R6");
    do_addr(8'h0E); do_write(8'h33); do_read(1'b0, "R6");
    do_addr(8'h40); do_write(8'h77); do_read(1'b0, "R6");

    // R8 stream enables
    do_addr(8'h01); do_write(8'h30);
    do_write(8'h10);

    // R9 gating: only bit 6 set keeps interrupt high
    do_addr(8'h00); do_write(8'h40);
    do_event();
    do_write(8'h44);
    chk("R9", "irq low when enabled", {127'd0, bus_irq_n}, 128'd0);

    // R10 acknowledge, and event on the committing edge
    do_read(1'b0, "R10");
    chk("R10", "irq cleared by read", {127'd0, bus_irq_n}, 128'd1);
    do_event();
    do_read(1'b1, "R10");
    chk("R10", "event wins over clear", {127'd0, bus_irq_n}, 128'd0);
    do_read(1'b0, "R10");

    // R11 no access without a valid strobe
    do_addr(8'h06);
    bus_cs_n = 1'b0; bus_rd_n = 1'b0; bus_wr_n = 1'b0; bus_din = 8'hEE;
    repeat (10) @(negedge clk);
    chk("R11", "both strobes: rdy_n", {127'd0, bus_rdy_n}, 128'd1);
    bus_cs_n = 1'b1; bus_rd_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R11", "cs high: rdy_n", {127'd0, bus_rdy_n}, 128'd1);
    chk("R11", "no register change", reg_image_o, b_image());
    bus_wr_n = 1'b1;
    repeat (2) @(negedge clk);

    // random traffic
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op <= 2) begin
        if ($urandom_range(0, 5) == 0) do_addr(8'($urandom_range(16, 255)));
        else                           do_addr(8'($urandom_range(0, 15)));
      end else if (op <= 5) begin
        if (m_idx == 8'h00 && $urandom_range(0, 1) == 1) do_write(8'h44);
        else do_write(8'($urandom));
      end else if (op <= 8) begin
        do_read(1'b0, "R6");
      end else begin
        do_event();
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule